// File: doc/BRIEF.md
# NAND Page ECC Geometry Locator

This block turns the size of a NAND page into the layout an ECC engine needs. On a start pulse it captures the data area size, the spare area size, an ONFI flag and a swap enable. From these it derives the following values:

- the ECC chunk size and the number of chunks;
- the correction strength;
- the number of bytes moved per page;
- the auxiliary buffer size, which holds metadata and per-chunk status;
- the offset of the status bytes inside the auxiliary buffer.

When swapping is enabled, the block also finds where the factory bad-block mark falls once the page is viewed as corrected data only. It does this by stepping over the interleaved data and parity chunks. It rejects a layout in which the mark would sit inside parity bits.

All divisions are done by an internal restoring divider that produces one quotient bit per clock. A result therefore takes a few tens of cycles. The result is presented with a one-cycle done pulse and an error flag. The output registers hold their values until the next accepted start.

Top module: `nand_geom_locator`

## Requirements
- R1: The chunk size is 512 bytes, or 1024 bytes when the ONFI flag is set. The chunk count equals the data size divided by the chunk size.
- R2: The strength is chosen from the page size:
  - 2048-byte data: strength 8.
  - 4096-byte data with 128 spare bytes: strength 8.
  - 4096-byte data with 218 spare bytes: strength 16.
  - 8192-byte data: strength 24.
- R3: Any other data/spare pair finishes with err=1, and with strength, chunk fields, sizes and mark offsets all 0.
- R4: The transfer size is data + spare. The one exception is an ONFI page with 8192 data bytes, where it is data + META_BYTES + strength*112/chunk count.
- R5: The status offset is META_BYTES rounded up to a multiple of 4. The auxiliary size is that value plus the chunk count rounded up to a multiple of 4.
- R6: With swapping enabled, the mark position is computed in these steps:
  - Take P = data*8 - META_BYTES*8.
  - Compute the parity bits per chunk, Q = strength*13, or strength*14 with the ONFI flag.
  - Divide P by (chunk*8 + Q). The quotient is the chunk index k.
  - The mark byte is (P - k*Q) / 8, and the mark bit is (P - k*Q) mod 8.
- R7: If the remainder of the R6 division exceeds chunk*8, the mark lies in parity. The block then finishes with err=1, mark offsets 0, and the other layout fields still valid.
- R8: With swapping disabled, the mark byte and mark bit are 0 and no mark division is run.
- R9: done is high for exactly one cycle per accepted start. busy is high from the cycle after start until done. The results stay stable until the next accepted start.
- R10: A start pulse while busy is high is ignored, and the result reflects the first captured inputs.
- R11: After reset, done, busy, err and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture inputs and begin (ignored while busy) |
| page_data_bytes | input | SZW | Data area size in bytes |
| page_spare_bytes | input | SZW | Spare area size in bytes |
| onfi_mode | input | 1 | Selects 1024-byte chunks and 14-bit parity symbols |
| swap_en | input | 1 | Enables the bad-block mark computation |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Unsupported layout or mark inside parity |
| chunk_bytes | output | SZW | ECC chunk size |
| chunk_cnt | output | SZW | Chunks per page |
| ecc_strength | output | STW | Correctable bits per chunk |
| xfer_bytes | output | SZW | Bytes transferred per page |
| aux_bytes | output | SZW | Auxiliary buffer size |
| status_off | output | SZW | Status area offset in auxiliary buffer |
| mark_byte | output | SZW | Mark byte offset in corrected data |
| mark_bit | output | 3 | Mark bit offset within that byte |

## Verification
The bench builds two copies of the block, both with default widths. One uses the default metadata size of 10 bytes. The other uses META_BYTES=741, which pushes the status offset to a rounded value (744) and moves the mark into a different chunk. With that metadata size, an ONFI 8192-byte page puts the mark inside parity, which is the only way to reach the parity rejection path, since every supported layout at 10 bytes keeps the mark in data.

// File: rtl/gl_pkg.sv
package gl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SETUP = 3'd1,
      ST_XDIV  = 3'd2,
      ST_MDIV  = 3'd3,
      ST_FIN   = 3'd4
   } gl_state_e;

   localparam int SMALL_CHUNK = 512;
   localparam int LARGE_CHUNK = 1024;
   localparam int SYM_STD     = 13;
   localparam int SYM_ONFI    = 14;
endpackage

// File: rtl/gl_strength_sel.sv
module gl_strength_sel #(
   parameter int SZW = 16,
   parameter int STW = 6
) (
   input  logic [SZW-1:0] data_bytes,
   input  logic [SZW-1:0] spare_bytes,
   output logic [STW-1:0] strength
);
   always_comb begin
      strength = '0;
      if (data_bytes == SZW'(2048))
         strength = STW'(8);
      else if (data_bytes == SZW'(4096)) begin
         if (spare_bytes == SZW'(128))      strength = STW'(8);
         else if (spare_bytes == SZW'(218)) strength = STW'(16);
      end else if (data_bytes == SZW'(8192))
         strength = STW'(24);
   end
endmodule

// File: rtl/gl_restoring_div.sv
module gl_restoring_div #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic         done,
   output logic [W-1:0] quot,
   output logic [W-1:0] rem
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  rem_q, quo_q, dsr_q, dvd_q;
   logic [CW-1:0] cnt_q;
   logic          act_q, done_q;
   logic [W:0]    shifted, trial;

   assign shifted = {rem_q, quo_q[W-1]};
   assign trial   = shifted - {1'b0, dsr_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         quo_q  <= '0;
         dsr_q  <= '0;
         dvd_q  <= '0;
         cnt_q  <= '0;
         act_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (go) begin
            rem_q <= '0;
            quo_q <= dividend;
            dvd_q <= dividend;
            dsr_q <= divisor;
            cnt_q <= CW'(W);
            act_q <= 1'b1;
         end else if (act_q) begin
            if (!trial[W]) begin
               rem_q <= trial[W-1:0];
               quo_q <= {quo_q[W-2:0], 1'b1};
            end else begin
               rem_q <= shifted[W-1:0];
               quo_q <= {quo_q[W-2:0], 1'b0};
            end
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
               act_q  <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign done = done_q;
   assign quot = quo_q;
   assign rem  = rem_q;

   // R6: remainder below divisor once finished
   a_r6_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && dsr_q != '0) |-> (rem_q < dsr_q));

   // R6: quotient and remainder rebuild the dividend
   a_r6_div_identity: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> ((2*W)'(quo_q) * (2*W)'(dsr_q) + (2*W)'(rem_q) == (2*W)'(dvd_q)));
endmodule

// File: rtl/nand_geom_locator.sv
module nand_geom_locator #(
   parameter int SZW        = 16,
   parameter int STW        = 6,
   parameter int DIVW       = 24,
   parameter int META_BYTES = 10
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [SZW-1:0] page_data_bytes,
   input  logic [SZW-1:0] page_spare_bytes,
   input  logic           onfi_mode,
   input  logic           swap_en,
   output logic           busy,
   output logic           done,
   output logic           err,
   output logic [SZW-1:0] chunk_bytes,
   output logic [SZW-1:0] chunk_cnt,
   output logic [STW-1:0] ecc_strength,
   output logic [SZW-1:0] xfer_bytes,
   output logic [SZW-1:0] aux_bytes,
   output logic [SZW-1:0] status_off,
   output logic [SZW-1:0] mark_byte,
   output logic [2:0]     mark_bit
);
   import gl_pkg::*;

   localparam int META_RND = ((META_BYTES + 3) / 4) * 4;
   localparam int ONFI_BIG = 8192;

   if (DIVW < SZW + 4) begin : g_bad_divw
      $error("DIVW must hold the page size in bits");
   end
   if (STW < 5) begin : g_bad_stw
      $error("STW too narrow for strength 24");
   end
   if (META_BYTES < 1 || META_BYTES * 8 >= 2048 * 8) begin : g_bad_meta
      $error("META_BYTES out of range");
   end

   gl_state_e      st_q;
   logic [SZW-1:0] data_q, spare_q;
   logic           onfi_q, swap_q;

   logic [STW-1:0]  str_w;
   logic [SZW-1:0]  chunk_w, cnt_w, cnt_rnd_w;
   logic [DIVW-1:0] cbits_w, par_w, tot_w, mbits_w, adj_w;

   logic            div_go_q, div_done;
   logic [DIVW-1:0] div_a_q, div_b_q, div_quot, div_rem;

   gl_strength_sel #(.SZW(SZW), .STW(STW)) u_str (
      .data_bytes (data_q),
      .spare_bytes(spare_q),
      .strength   (str_w)
   );

   gl_restoring_div #(.W(DIVW)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (div_go_q),
      .dividend(div_a_q),
      .divisor (div_b_q),
      .done    (div_done),
      .quot    (div_quot),
      .rem     (div_rem)
   );

   assign chunk_w   = onfi_q ? SZW'(LARGE_CHUNK) : SZW'(SMALL_CHUNK);
   assign cnt_w     = onfi_q ? (data_q >> 10) : (data_q >> 9);
   assign cnt_rnd_w = (cnt_w + SZW'(3)) & ~SZW'(3);
   assign cbits_w   = DIVW'(chunk_w) << 3;
   assign par_w     = DIVW'(ecc_strength) * (onfi_q ? DIVW'(SYM_ONFI) : DIVW'(SYM_STD));
   assign tot_w     = cbits_w + par_w;
   assign mbits_w   = (DIVW'(data_q) << 3) - DIVW'(META_BYTES * 8);
   assign adj_w     = mbits_w - div_quot * par_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_IDLE;
         data_q       <= '0;
         spare_q      <= '0;
         onfi_q       <= 1'b0;
         swap_q       <= 1'b0;
         div_go_q     <= 1'b0;
         div_a_q      <= '0;
         div_b_q      <= '0;
         err          <= 1'b0;
         chunk_bytes  <= '0;
         chunk_cnt    <= '0;
         ecc_strength <= '0;
         xfer_bytes   <= '0;
         aux_bytes    <= '0;
         status_off   <= '0;
         mark_byte    <= '0;
         mark_bit     <= '0;
      end else begin
         div_go_q <= 1'b0;
         case (st_q)
            ST_IDLE: if (start) begin
               data_q       <= page_data_bytes;
               spare_q      <= page_spare_bytes;
               onfi_q       <= onfi_mode;
               swap_q       <= swap_en;
               err          <= 1'b0;
               chunk_bytes  <= '0;
               chunk_cnt    <= '0;
               ecc_strength <= '0;
               xfer_bytes   <= '0;
               aux_bytes    <= '0;
               status_off   <= '0;
               mark_byte    <= '0;
               mark_bit     <= '0;
               st_q         <= ST_SETUP;
            end
            ST_SETUP: begin
               if (str_w == '0) begin
                  err  <= 1'b1;
                  st_q <= ST_FIN;
               end else begin
                  chunk_bytes  <= chunk_w;
                  chunk_cnt    <= cnt_w;
                  ecc_strength <= str_w;
                  xfer_bytes   <= data_q + spare_q;
                  status_off   <= SZW'(META_RND);
                  aux_bytes    <= SZW'(META_RND) + cnt_rnd_w;
                  if (onfi_q && data_q == SZW'(ONFI_BIG)) begin
                     div_a_q  <= DIVW'(str_w) * DIVW'(SYM_ONFI * 8);
                     div_b_q  <= DIVW'(cnt_w);
                     div_go_q <= 1'b1;
                     st_q     <= ST_XDIV;
                  end else if (swap_q) begin
                     st_q <= ST_SETUP;
                     st_q <= ST_MDIV;
                  end else
                     st_q <= ST_FIN;
               end
            end
            ST_XDIV: if (div_done) begin
               xfer_bytes <= data_q + SZW'(META_BYTES) + SZW'(div_quot);
               st_q       <= swap_q ? ST_MDIV : ST_FIN;
            end
            ST_MDIV: begin
               if (div_done) begin
                  if (div_rem > cbits_w)
                     err <= 1'b1;
                  else begin
                     mark_byte <= SZW'(adj_w >> 3);
                     mark_bit  <= adj_w[2:0];
                  end
                  st_q <= ST_FIN;
               end
            end
            ST_FIN:  st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
         // Mark division launched on entry to ST_MDIV from either path
         if ((st_q == ST_SETUP && str_w != '0 && swap_q &&
              !(onfi_q && data_q == SZW'(ONFI_BIG))) ||
             (st_q == ST_XDIV && div_done && swap_q)) begin
            div_a_q  <= mbits_w;
            div_b_q  <= (st_q == ST_SETUP)
                        ? cbits_w + DIVW'(str_w) * (onfi_q ? DIVW'(SYM_ONFI) : DIVW'(SYM_STD))
                        : tot_w;
            div_go_q <= 1'b1;
         end
      end
   end

   assign busy = (st_q != ST_IDLE) && (st_q != ST_FIN);
   assign done = (st_q == ST_FIN);

   // R9: done lasts one cycle
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: results held while idle
   a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && !start) |=> ($stable(xfer_bytes) && $stable(mark_byte) && $stable(err)));

   // R10: captured inputs unchanged by start while busy
   a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(data_q) && $stable(spare_q) && $stable(swap_q)));

   // R8: no mark without swapping
   a_r8_no_mark: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !swap_q) |-> (mark_byte == '0 && mark_bit == '0));

   // R3: zero strength only with error
   a_r3_zero_strength_err: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ecc_strength == '0) |-> err);

   // R5: status offset word aligned and below aux size
   a_r5_status_align: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> (status_off[1:0] == 2'b00 && aux_bytes > status_off));
endmodule

// File: tb/nand_geom_locator_tb_top.sv
module nand_geom_locator_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int SZW = 16;
   localparam int STW = 6;

   typedef struct packed {
      logic [15:0] data;
      logic [15:0] spare;
      logic        onfi;
      logic        swap;
      logic        e_err;
      logic [7:0]  e_str;
      logic [15:0] e_cnt;
      logic [15:0] e_chunk;
      logic [15:0] e_xfer;
      logic [15:0] e_aux;
      logic [15:0] e_soff;
      logic [15:0] e_mbyte;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t TBL [NV] = '{
      '{16'd2048, 16'd64,  1'b0, 1'b1, 1'b0, 8'd8,  16'd4,  16'd512,  16'd2112, 16'd16, 16'd12, 16'd1999},
      '{16'd2048, 16'd64,  1'b1, 1'b1, 1'b0, 8'd8,  16'd2,  16'd1024, 16'd2112, 16'd16, 16'd12, 16'd2024},
      '{16'd4096, 16'd128, 1'b0, 1'b1, 1'b0, 8'd8,  16'd8,  16'd512,  16'd4224, 16'd20, 16'd12, 16'd3995},
      '{16'd4096, 16'd218, 1'b0, 1'b1, 1'b0, 8'd16, 16'd8,  16'd512,  16'd4314, 16'd20, 16'd12, 16'd3904},
      '{16'd8192, 16'd448, 1'b0, 1'b1, 1'b0, 8'd24, 16'd16, 16'd512,  16'd8640, 16'd28, 16'd12, 16'd7636},
      '{16'd8192, 16'd448, 1'b1, 1'b1, 1'b0, 8'd24, 16'd8,  16'd1024, 16'd8538, 16'd20, 16'd12, 16'd7888},
      '{16'd4096, 16'd218, 1'b1, 1'b1, 1'b0, 8'd16, 16'd4,  16'd1024, 16'd4314, 16'd16, 16'd12, 16'd4002},
      '{16'd2048, 16'd64,  1'b0, 1'b0, 1'b0, 8'd8,  16'd4,  16'd512,  16'd2112, 16'd16, 16'd12, 16'd0},
      '{16'd4096, 16'd224, 1'b0, 1'b1, 1'b1, 8'd0,  16'd0,  16'd0,    16'd0,    16'd0,  16'd0,  16'd0},
      '{16'd1024, 16'd32,  1'b0, 1'b1, 1'b1, 8'd0,  16'd0,  16'd0,    16'd0,    16'd0,  16'd0,  16'd0}
   };

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, onfi = 1'b0, swap = 1'b0;
   logic [SZW-1:0] pdata = '0, pspare = '0;

   logic busy_a, done_a, err_a, busy_b, done_b, err_b;
   logic [SZW-1:0] chunk_a, cnt_a, xfer_a, aux_a, soff_a, mbyte_a;
   logic [SZW-1:0] chunk_b, cnt_b, xfer_b, aux_b, soff_b, mbyte_b;
   logic [STW-1:0] str_a, str_b;
   logic [2:0]     mbit_a, mbit_b;

   int checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nand_geom_locator #(.SZW(SZW), .STW(STW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .page_data_bytes(pdata),
      .page_spare_bytes(pspare), .onfi_mode(onfi), .swap_en(swap),
      .busy(busy_a), .done(done_a), .err(err_a), .chunk_bytes(chunk_a),
      .chunk_cnt(cnt_a), .ecc_strength(str_a), .xfer_bytes(xfer_a),
      .aux_bytes(aux_a), .status_off(soff_a), .mark_byte(mbyte_a), .mark_bit(mbit_a));

   nand_geom_locator #(.SZW(SZW), .STW(STW), .META_BYTES(741)) dut_meta_i (
      .clk(clk), .rst_n(rst_n), .start(start), .page_data_bytes(pdata),
      .page_spare_bytes(pspare), .onfi_mode(onfi), .swap_en(swap),
      .busy(busy_b), .done(done_b), .err(err_b), .chunk_bytes(chunk_b),
      .chunk_cnt(cnt_b), .ecc_strength(str_b), .xfer_bytes(xfer_b),
      .aux_bytes(aux_b), .status_off(soff_b), .mark_byte(mbyte_b), .mark_bit(mbit_b));

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic launch(input int d, input int s, input logic o, input logic w);
      @(negedge clk);
      pdata = SZW'(d); pspare = SZW'(s); onfi = o; swap = w; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (!done_a && n < 1000) begin
         @(negedge clk);
         n++;
      end
      if (!done_a) check("R9 watchdog done", 0, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 done", int'(done_a), 0);
      check("R11 busy", int'(busy_a), 0);
      check("R11 err", int'(err_a), 0);
      check("R11 strength", int'(str_a), 0);
      check("R11 xfer", int'(xfer_a), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 idle busy after release", int'(busy_a), 0);

      for (int i = 0; i < NV; i++) begin
         launch(TBL[i].data, TBL[i].spare, TBL[i].onfi, TBL[i].swap);
         check("R9 busy after start", int'(busy_a), 1);
         wait_done();
         check("R3 R7 err", int'(err_a), int'(TBL[i].e_err));
         check("R2 strength", int'(str_a), int'(TBL[i].e_str));
         check("R1 chunk count", int'(cnt_a), int'(TBL[i].e_cnt));
         check("R1 chunk size", int'(chunk_a), int'(TBL[i].e_chunk));
         check("R4 transfer", int'(xfer_a), int'(TBL[i].e_xfer));
         check("R5 aux", int'(aux_a), int'(TBL[i].e_aux));
         check("R5 status offset", int'(soff_a), int'(TBL[i].e_soff));
         check("R6 R8 mark byte", int'(mbyte_a), int'(TBL[i].e_mbyte));
         check("R6 R8 mark bit", int'(mbit_a), 0);
         @(negedge clk);
         check("R9 done single", int'(done_a), 0);
         check("R9 held", int'(xfer_a), int'(TBL[i].e_xfer));
      end

      // R10: second start while busy ignored
      launch(2048, 64, 1'b0, 1'b1);
      repeat (3) @(negedge clk);
      pdata = 16'd4096; pspare = 16'd218; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      check("R10 strength unchanged", int'(str_a), 8);
      check("R10 mark unchanged", int'(mbyte_a), 1999);
      @(negedge clk);
      check("R10 no second done", int'(done_a), 0);
      repeat (40) @(negedge clk);
      check("R10 still idle", int'(busy_a), 0);

      // R5 R6 with META_BYTES=741 copy
      launch(2048, 64, 1'b0, 1'b1);
      wait_done();
      check("R5 meta status offset", int'(soff_b), 744);
      check("R5 meta aux", int'(aux_b), 748);
      check("R6 meta mark byte", int'(mbyte_b), 1281);
      check("R6 meta err", int'(err_b), 0);

      // R7 mark inside parity (ONFI 8192, META 741)
      launch(8192, 448, 1'b1, 1'b1);
      wait_done();
      check("R7 parity err", int'(err_b), 1);
      check("R7 mark cleared", int'(mbyte_b), 0);
      check("R7 strength kept", int'(str_b), 24);
      check("R4 meta transfer", int'(xfer_b), 8192 + 741 + 336);
      check("R7 default copy ok", int'(err_a), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule